// File: doc/BRIEF.md
# Flash Page-Program Phase Engine

This block drives a four-lane serial flash bus through one complete write operation made of four phases that always run in the same order: an opcode, an address, a stretch of dummy cycles and a data payload. Each phase is described by its own configuration word, which holds a lane-width field and a bus-cycle count. The opcode, address and dummy phases send the contents of their own code registers. The data phase streams bytes from a word-packed transmit buffer.

Software first writes the transmit buffer, the three code registers and the four configuration words. It then selects this engine through the mode register and writes the GO bit. The GO bit stays set while the engine runs and clears itself once the last phase has finished, so software polls it to detect completion. A phase whose cycle count is zero produces no bus clock edges at all. Every active lane is driven as an output in every phase. Receive paths, clock division and chip-select timing belong to neighbouring logic.

Top module: `qspi_pp_engine`

## Requirements
- R1: After reset go_busy, sck, sio_oe and sio_out are all 0, and the mode register holds 0, which selects no engine.
- R2: A write of 1 to bit 0 of register index 1 (GO) starts the engine only when the mode register (index 0) holds exactly 0x100. Mode values such as 1, 2 or 0x101 leave go_busy low and produce no sck pulse.
- R3: The phases run in the fixed order opcode, address, dummy, data. Their configuration words sit at indices 3, 5, 7 and 8, with the lane field in bits [19:16] and the cycle count in bits [15:0]. A lane field of 2 means two lanes, 4 means four lanes, and every other value means one lane.
- R4: The opcode, address and dummy phases send the low cycles×lanes bits of their code registers (indices 2, 4 and 6), most significant bit first. Bits above bit 31 are sent as 0. In each bus cycle the earliest bit goes on the highest active lane, sio_out[lanes-1].
- R5: The data phase sends payload bytes in ascending order from byte 0. Byte k is bits [8*(k%4)+7 : 8*(k%4)] of buffer word k/4, and each byte goes most significant bit first. The lane mapping is the same as in R4. Up to 256 bytes fit.
- R6: A phase with a cycle count of 0 is skipped. It produces no sck pulse and takes one clock with sck, sio_oe and sio_out at 0.
- R7: Each bus cycle takes two clocks: one with sck low, then one with sck high. sio_out and sio_oe do not change across the sck-high clock, and sck never stays high for two clocks in a row.
- R8: While a phase with a nonzero cycle count is running, sio_oe is 0001, 0011 or 1111 for one, two or four lanes. Outside such phases sio_oe and sio_out are 0, and sio_out is never 1 on a lane that is not enabled.
- R9: go_busy rises in the clock after the accepted GO write. It stays high for exactly the sum, over the four phases, of 2×cycles, counting a skipped phase as 1, and then clears by itself.
- R10: While go_busy is high, all register writes (mode, codes, configurations, GO) and all buffer writes are ignored. A buffer write in the same clock as the accepted GO write is taken and shows up in the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index (0 mode, 1 GO, 2/4/6 codes, 3/5/7/8 configurations) |
| cfg_wdata | input | 32 | Register write data |
| buf_we | input | 1 | Transmit buffer write strobe |
| buf_widx | input | 6 | Transmit buffer word index |
| buf_wdata | input | 32 | Transmit buffer word, byte 0 of the word in bits [7:0] |
| go_busy | output | 1 | GO bit; high while an operation runs |
| sck | output | 1 | Serial bus clock, idles low |
| sio_out | output | 4 | Lane output values |
| sio_oe | output | 4 | Lane output enables |

## Verification
A buffer write and the GO write that starts the engine can fall in the same clock. They can because the buffer has its own write port, separate from the register port. The bench drives both strobes on one clock edge with a new value for word 0, and it expects the first payload bytes on the lanes to carry that new word. A second same-cycle case is a register write or a repeated GO landing while the engine is busy. The bench provokes this in the middle of a run, then starts a fresh run with only a GO write and checks that the duration and the lane pattern are unchanged.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  localparam int NUM_PH   = 4;
  localparam int NUM_CODE = 3;

  localparam logic [3:0] RI_MODE      = 4'd0;
  localparam logic [3:0] RI_GO        = 4'd1;
  localparam logic [3:0] RI_DATA_CONF = 4'd8;

  localparam logic [31:0] MODE_PAGE_PROG = 32'h0000_0100;

  // code registers of phases 0..2 sit at 2, 4, 6
  function automatic logic [3:0] code_index(input int p);
    return 4'(2 + 2 * p);
  endfunction

  // configuration words of phases 0..2 at 3, 5, 7; data phase at 8
  function automatic logic [3:0] conf_index(input int p);
    return (p == NUM_PH - 1) ? RI_DATA_CONF : 4'(3 + 2 * p);
  endfunction

  function automatic logic [2:0] lane_count(input logic [3:0] field);
    case (field)
      4'd2:    return 3'd2;
      4'd4:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/qpp_regs.sv
module qpp_regs
  import qpp_pkg::*;
#(
  parameter int CYC_W = 16   // at most 16: cycle field is bits [15:0]
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [3:0]                         cfg_addr,
  input  logic [31:0]                        cfg_wdata,
  input  logic                               busy,
  output logic                               pp_sel,
  output logic                               start,
  output logic [NUM_CODE-1:0][31:0]          code,
  output logic [NUM_PH-1:0][CYC_W+3:0]       conf
);

  logic        wr_ok;
  logic        mode_en;
  logic [31:0] mode_q;

  assign wr_ok   = cfg_we & ~busy;
  assign mode_en = wr_ok & (cfg_addr == RI_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= cfg_wdata;
  end

  assign pp_sel = (mode_q == MODE_PAGE_PROG);
  assign start  = wr_ok & (cfg_addr == RI_GO) & cfg_wdata[0] & pp_sel;

  for (genvar g = 0; g < NUM_CODE; g++) begin : g_code
    logic        en;
    logic [31:0] q;
    assign en = wr_ok & (cfg_addr == code_index(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= cfg_wdata;
    end
    assign code[g] = q;
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_conf
    logic             en;
    logic [CYC_W+3:0] q;
    assign en = wr_ok & (cfg_addr == conf_index(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= {cfg_wdata[19:16], cfg_wdata[CYC_W-1:0]};
    end
    assign conf[g] = q;
  end

endmodule

// File: rtl/qpp_txbuf.sv
module qpp_txbuf #(
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             busy,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);

  logic [31:0] mem [WORDS];
  logic        wr_en;

  // writes are frozen while an operation runs
  assign wr_en = we & ~busy;

  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/qpp_seq.sv
module qpp_seq
  import qpp_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [NUM_PH-1:0][CYC_W+3:0] conf,
  output logic                         busy,
  output phase_e                       phase,
  output logic [CYC_W-1:0]             cyc,
  output logic [CYC_W-1:0]             cycles,
  output logic [2:0]                   lanes,
  output logic                         active,
  output logic                         sck
);

  logic             busy_q, busy_d;
  phase_e           ph_q, ph_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             half_q, half_d;
  logic             en;
  logic [CYC_W+3:0] cur;

  assign cur    = conf[ph_q];
  assign cycles = cur[CYC_W-1:0];
  assign lanes  = lane_count(cur[CYC_W+3:CYC_W]);
  assign active = busy_q & (cycles != '0);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    cyc_d  = cyc_q;
    half_d = half_q;
    if (start) begin
      busy_d = 1'b1;
      ph_d   = PH_CMD;
      cyc_d  = '0;
      half_d = 1'b0;
    end else if (busy_q) begin
      if (cycles == '0) begin
        // empty phase: one idle clock, no bus edges
        if (ph_q == PH_DATA) busy_d = 1'b0;
        else                 ph_d   = phase_e'(ph_q + 2'd1);
      end else if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (cyc_q == cycles - CYC_W'(1)) begin
          cyc_d = '0;
          if (ph_q == PH_DATA) busy_d = 1'b0;
          else                 ph_d   = phase_e'(ph_q + 2'd1);
        end else begin
          cyc_d = cyc_q + CYC_W'(1);
        end
      end
    end
  end

  assign en = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_CMD;
      cyc_q  <= '0;
      half_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      cyc_q  <= cyc_d;
      half_q <= half_d;
    end
  end

  assign busy  = busy_q;
  assign phase = ph_q;
  assign cyc   = cyc_q;
  assign sck   = active & half_q;

endmodule

// File: rtl/qpp_ser.sv
module qpp_ser
  import qpp_pkg::*;
#(
  parameter int CYC_W     = 16,
  parameter int BUF_BYTES = 256,
  localparam int BYTE_W   = $clog2(BUF_BYTES),
  localparam int WIDX_W   = BYTE_W - 2
) (
  input  phase_e                     phase,
  input  logic [CYC_W-1:0]           cyc,
  input  logic [CYC_W-1:0]           cycles,
  input  logic [2:0]                 lanes,
  input  logic                       active,
  input  logic [NUM_CODE-1:0][31:0]  code,
  input  logic [31:0]                buf_word,
  output logic [WIDX_W-1:0]          word_idx,
  output logic [3:0]                 sio_out,
  output logic [3:0]                 sio_oe
);

  logic [CYC_W+2:0] s0v;      // first stream bit of this bus cycle
  logic [31:0]      code_sel;
  logic [7:0]       data_byte;
  logic [3:0]       nib_top;
  logic [3:0]       nib_data;
  logic [3:0]       nib_code;

  assign s0v      = {3'b000, cyc} * {{CYC_W{1'b0}}, lanes};
  assign word_idx = s0v[BYTE_W+2:5];

  always_comb begin
    case (phase)
      PH_ADDR:  code_sel = code[1];
      PH_DUMMY: code_sel = code[2];
      default:  code_sel = code[0];
    endcase
  end

  // opcode/address/dummy: low nb bits of the code, MSB first
  always_comb begin
    int nb, s0, nl, idx;
    nb       = int'(cycles) * int'(lanes);
    s0       = int'(s0v);
    nl       = int'(lanes);
    idx      = 0;
    nib_code = '0;
    for (int p = 0; p < 4; p++) begin
      if (p < nl) begin
        idx = nb - 1 - s0 - (nl - 1 - p);
        if (idx >= 0 && idx < 32)
          nib_code[p] = |(code_sel & (32'd1 << idx));
      end
    end
  end

  // data: byte lane of the word, then bits from the MSB end
  always_comb begin
    case (s0v[4:3])
      2'd0:    data_byte = buf_word[7:0];
      2'd1:    data_byte = buf_word[15:8];
      2'd2:    data_byte = buf_word[23:16];
      default: data_byte = buf_word[31:24];
    endcase
    nib_top = 4'((data_byte << s0v[2:0]) >> 4);
    case (lanes)
      3'd4:    nib_data = nib_top;
      3'd2:    nib_data = {2'b00, nib_top[3:2]};
      default: nib_data = {3'b000, nib_top[3]};
    endcase
  end

  assign sio_out = active ? ((phase == PH_DATA) ? nib_data : nib_code) : 4'b0000;
  assign sio_oe  = active ? lane_mask(lanes) : 4'b0000;

endmodule

// File: rtl/qspi_pp_engine.sv
module qspi_pp_engine
  import qpp_pkg::*;
#(
  parameter int CYC_W     = 16,
  parameter int BUF_BYTES = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [3:0]                     cfg_addr,
  input  logic [31:0]                    cfg_wdata,
  input  logic                           buf_we,
  input  logic [$clog2(BUF_BYTES)-3:0]   buf_widx,
  input  logic [31:0]                    buf_wdata,
  output logic                           go_busy,
  output logic                           sck,
  output logic [3:0]                     sio_out,
  output logic [3:0]                     sio_oe
);

  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WIDX_W = $clog2(WORDS);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                         pp_sel;
  logic                         start;
  logic                         busy;
  logic [NUM_CODE-1:0][31:0]    code;
  logic [NUM_PH-1:0][CYC_W+3:0] conf;
  phase_e                       phase;
  logic [CYC_W-1:0]             cyc;
  logic [CYC_W-1:0]             cycles;
  logic [2:0]                   lanes;
  logic                         active;
  logic [WIDX_W-1:0]            rd_idx;
  logic [31:0]                  rd_word;

  qpp_regs #(.CYC_W(CYC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .pp_sel    (pp_sel),
    .start     (start),
    .code      (code),
    .conf      (conf)
  );

  qpp_txbuf #(.WORDS(WORDS)) u_buf (
    .clk   (clk),
    .busy  (busy),
    .we    (buf_we),
    .widx  (buf_widx),
    .wdata (buf_wdata),
    .ridx  (rd_idx),
    .rdata (rd_word)
  );

  qpp_seq #(.CYC_W(CYC_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .conf   (conf),
    .busy   (busy),
    .phase  (phase),
    .cyc    (cyc),
    .cycles (cycles),
    .lanes  (lanes),
    .active (active),
    .sck    (sck)
  );

  qpp_ser #(.CYC_W(CYC_W), .BUF_BYTES(BUF_BYTES)) u_ser (
    .phase    (phase),
    .cyc      (cyc),
    .cycles   (cycles),
    .lanes    (lanes),
    .active   (active),
    .code     (code),
    .buf_word (rd_word),
    .word_idx (rd_idx),
    .sio_out  (sio_out),
    .sio_oe   (sio_oe)
  );

  assign go_busy = busy;

endmodule

// File: rtl/qspi_pp_engine_chk.sv
module qspi_pp_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        pp_sel,
  input logic        go_busy,
  input logic        sck,
  input logic [3:0]  sio_out,
  input logic [3:0]  sio_oe
);

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_busy) |-> $past(cfg_we && cfg_addr == 4'd1 && cfg_wdata[0] && pp_sel));

  assert_sck_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);

  assert_lanes_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> ($stable(sio_out) && $stable(sio_oe)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !go_busy |-> (!sck && sio_oe == 4'b0000 && sio_out == 4'b0000));

  assert_oe_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'b0000 || sio_oe == 4'b0001 || sio_oe == 4'b0011 || sio_oe == 4'b1111));

  assert_out_on_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_out & ~sio_oe) == 4'b0000);

  assert_edge_has_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> sio_oe != 4'b0000);

endmodule

bind qspi_pp_engine qspi_pp_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .pp_sel    (pp_sel),
  .go_busy   (go_busy),
  .sck       (sck),
  .sio_out   (sio_out),
  .sio_oe    (sio_oe)
);

// File: tb/qspi_pp_engine_test.sv
module qspi_pp_engine_test;

  localparam int BUF_BYTES = 256;
  localparam int WORDS     = BUF_BYTES / 4;
  localparam int MAXP      = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        buf_we = 1'b0;
  logic [5:0]  buf_widx = '0;
  logic [31:0] buf_wdata = '0;
  logic        go_busy, sck;
  logic [3:0]  sio_out, sio_oe;

  always #4 clk = ~clk;

  qspi_pp_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_we(buf_we), .buf_widx(buf_widx),
    .buf_wdata(buf_wdata), .go_busy(go_busy), .sck(sck),
    .sio_out(sio_out), .sio_oe(sio_oe)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  logic [7:0]  mdl [BUF_BYTES];
  logic [3:0]  exp_sio [MAXP];
  logic [3:0]  exp_oe  [MAXP];
  logic [3:0]  cap_sio [MAXP];
  logic [3:0]  cap_oe  [MAXP];
  int          exp_n, exp_clk, cap_n, busy_n;

  logic [31:0] s_code [3];
  logic [3:0]  s_lf   [4];
  int          s_cyc  [4];

  always @(negedge clk) begin
    if (go_busy) busy_n++;
    if (sck) begin
      if (cap_n < MAXP) begin
        cap_sio[cap_n] = sio_out;
        cap_oe[cap_n]  = sio_oe;
      end
      cap_n++;
    end
  end

  function automatic int lanes_of(input logic [3:0] f);
    if (f == 4'd2) return 2;
    if (f == 4'd4) return 4;
    return 1;
  endfunction

  function automatic logic [3:0] mask_of(input int l);
    return (l == 4) ? 4'b1111 : (l == 2) ? 4'b0011 : 4'b0001;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic build_exp();
    exp_n = 0;
    exp_clk = 0;
    for (int ph = 0; ph < 4; ph++) begin
      int l, c, nb;
      l  = lanes_of(s_lf[ph]);
      c  = s_cyc[ph];
      nb = c * l;
      exp_clk += (c == 0) ? 1 : 2 * c;
      for (int cy = 0; cy < c; cy++) begin
        logic [3:0] nib;
        nib = '0;
        for (int j = 0; j < l; j++) begin
          int s, idx;
          logic b;
          s = cy * l + j;
          if (ph < 3) begin
            idx = nb - 1 - s;
            b = (idx < 32) ? s_code[ph][idx] : 1'b0;
          end else begin
            b = mdl[(s / 8) % BUF_BYTES][7 - (s % 8)];
          end
          nib[l - 1 - j] = b;
        end
        if (exp_n < MAXP) begin
          exp_sio[exp_n] = nib;
          exp_oe[exp_n]  = mask_of(l);
        end
        exp_n++;
      end
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic buf_write(input int idx, input logic [31:0] d, input bit track);
    @(negedge clk);
    buf_we = 1'b1; buf_widx = 6'(idx); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
    if (track)
      for (int k = 0; k < 4; k++) mdl[idx * 4 + k] = d[8 * k +: 8];
  endtask

  task automatic program_regs();
    cfg_write(4'd2, s_code[0]);
    cfg_write(4'd4, s_code[1]);
    cfg_write(4'd6, s_code[2]);
    cfg_write(4'd3, {12'd0, s_lf[0], 16'(s_cyc[0])});
    cfg_write(4'd5, {12'd0, s_lf[1], 16'(s_cyc[1])});
    cfg_write(4'd7, {12'd0, s_lf[2], 16'(s_cyc[2])});
    cfg_write(4'd8, {12'd0, s_lf[3], 16'(s_cyc[3])});
  endtask

  task automatic go_and_check(input string req, input bit with_buf,
                              input int bidx, input logic [31:0] bdata);
    int guard, mism;
    cap_n = 0;
    busy_n = 0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 32'd1;
    if (with_buf) begin
      buf_we = 1'b1; buf_widx = 6'(bidx); buf_wdata = bdata;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    buf_we = 1'b0;
    guard = 0;
    while (go_busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(busy_n == exp_clk, req, "GO busy clocks (R9)", busy_n, exp_clk);
    chk(cap_n == exp_n, req, "sck pulse count", cap_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < cap_n && i < MAXP; i++)
      if (mism < 0 && (cap_sio[i] !== exp_sio[i] || cap_oe[i] !== exp_oe[i]))
        mism = i;
    if (mism >= 0)
      chk(1'b0, req, $sformatf("lanes {oe,out} at pulse %0d", mism),
          int'({cap_oe[mism], cap_sio[mism]}), int'({exp_oe[mism], exp_sio[mism]}));
    else
      chk(1'b1, req, "lane pattern", 0, 0);
  endtask

  task automatic set_ops(input logic [31:0] c0, input logic [3:0] l0, input int n0,
                         input logic [31:0] c1, input logic [3:0] l1, input int n1,
                         input logic [31:0] c2, input logic [3:0] l2, input int n2,
                         input logic [3:0] l3, input int n3);
    s_code[0] = c0; s_lf[0] = l0; s_cyc[0] = n0;
    s_code[1] = c1; s_lf[1] = l1; s_cyc[1] = n1;
    s_code[2] = c2; s_lf[2] = l2; s_cyc[2] = n2;
    s_lf[3] = l3; s_cyc[3] = n3;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lsel [3];
    void'($urandom(32'd20250611));
    lsel[0] = 1; lsel[1] = 2; lsel[2] = 4;

    // R1: reset state, both during and after reset release
    repeat (3) @(negedge clk);
    chk(go_busy == 1'b0, "R1", "go_busy in reset", int'(go_busy), 0);
    chk(sck == 1'b0, "R1", "sck in reset", int'(sck), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sio_oe == 4'b0, "R1", "sio_oe after reset", int'(sio_oe), 0);
    chk(sio_out == 4'b0, "R1", "sio_out after reset", int'(sio_out), 0);

    for (int w = 0; w < WORDS; w++) buf_write(w, $urandom, 1'b1);

    // R2 / R1: default mode 0 and PIO-like modes ignore GO
    set_ops(32'h02, 4'd1, 8, 32'h0, 4'd1, 0, 32'h0, 4'd1, 0, 4'd1, 8);
    program_regs();
    foreach (lsel[i]) begin
      logic [31:0] mv;
      mv = (i == 0) ? 32'h0 : (i == 1) ? 32'h1 : 32'h101;
      if (i != 0) cfg_write(4'd0, mv);
      cap_n = 0; busy_n = 0;
      cfg_write(4'd1, 32'd1);
      repeat (12) @(negedge clk);
      chk(busy_n == 0, "R2", $sformatf("busy clocks with mode %0h", mv), busy_n, 0);
      chk(cap_n == 0, "R2", $sformatf("sck pulses with mode %0h", mv), cap_n, 0);
    end
    cfg_write(4'd0, 32'h100);

    // R3 R4 R5 R6 R7: single lane, three address bytes, empty dummy
    set_ops(32'h02, 4'd1, 8, 32'h00A1B2C3, 4'd1, 24, 32'h0, 4'd1, 0, 4'd1, 128);
    program_regs(); build_exp();
    go_and_check("R4_single_lane", 1'b0, 0, 0);

    // R3 R5: four lanes in every phase, odd byte count
    set_ops(32'h32, 4'd4, 2, 32'h12345678, 4'd4, 8, 32'h0, 4'd4, 2, 4'd4, 74);
    program_regs(); build_exp();
    go_and_check("R5_quad", 1'b0, 0, 0);

    // R3: two lanes everywhere
    set_ops(32'hA2, 4'd2, 4, 32'h00FEDCBA, 4'd2, 12, 32'h0, 4'd2, 3, 4'd2, 40);
    program_regs(); build_exp();
    go_and_check("R3_dual", 1'b0, 0, 0);

    // R6: every phase empty -> four idle clocks, no edges
    set_ops(32'h02, 4'd1, 0, 32'h0, 4'd1, 0, 32'h0, 4'd1, 0, 4'd1, 0);
    program_regs(); build_exp();
    go_and_check("R6_all_empty", 1'b0, 0, 0);

    // R3: unlisted lane fields 0 and 7 fall back to one lane
    set_ops(32'h9F, 4'd0, 8, 32'h00000ABC, 4'd7, 16, 32'h5, 4'd3, 4, 4'd0, 8);
    program_regs(); build_exp();
    go_and_check("R3_lane_fallback", 1'b0, 0, 0);

    // R5: full 256-byte payload on one lane
    set_ops(32'h02, 4'd1, 8, 32'h00010000, 4'd1, 24, 32'h0, 4'd1, 0, 4'd1, 2048);
    program_regs(); build_exp();
    go_and_check("R5_full_page", 1'b0, 0, 0);

    // R10: writes during a run are dropped, then a bare GO repeats the run
    set_ops(32'h02, 4'd1, 8, 32'h00ABCDEF, 4'd1, 24, 32'h0, 4'd1, 0, 4'd1, 128);
    program_regs(); build_exp();
    fork
      go_and_check("R10_busy_writes", 1'b0, 0, 0);
      begin
        wait (go_busy);
        repeat (3) @(negedge clk);
        cfg_write(4'd8, 32'h0001_0005);
        cfg_write(4'd0, 32'h1);
        cfg_write(4'd1, 32'h1);
        cfg_write(4'd2, 32'hFF);
        buf_write(0, 32'hDEADBEEF, 1'b0);
      end
    join
    go_and_check("R10_state_kept", 1'b0, 0, 0);

    // R10: buffer write in the GO clock is taken
    begin
      logic [31:0] nw;
      nw = 32'hC3A55A3C;
      for (int k = 0; k < 4; k++) mdl[k] = nw[8 * k +: 8];
      set_ops(32'h02, 4'd4, 2, 32'h0, 4'd1, 0, 32'h0, 4'd1, 0, 4'd4, 8);
      program_regs(); build_exp();
      go_and_check("R10_same_cycle_buf", 1'b1, 0, nw);
    end

    // random mix of lanes, lengths and empty phases
    for (int r = 0; r < 24; r++) begin
      int la, lb, lc, ld, ab, db, dc;
      la = lsel[$urandom % 3]; lb = lsel[$urandom % 3];
      lc = lsel[$urandom % 3]; ld = lsel[$urandom % 3];
      ab = $urandom % 5;
      dc = $urandom % 7;
      db = $urandom % 49;
      set_ops({24'd0, 8'($urandom)}, 4'(la), 8 / la,
              $urandom, 4'(lb), ab * 8 / lb,
              $urandom, 4'(lc), dc,
              4'(ld), db * 8 / ld);
      if (r % 6 == 5) begin
        for (int w = 0; w < WORDS; w++) buf_write(w, $urandom, 1'b1);
      end
      program_regs(); build_exp();
      go_and_check($sformatf("R4_R5_R9_random_%0d", r), 1'b0, 0, 0);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule